// File: doc/BRIEF.md
# Single-Track Bridge Interlock Monitor

This block is a synchronous runtime monitor for a single-track bridge shared by two routes. Route A runs from the first approach track to the third, and route B runs from the second approach track to the fourth. On every clock edge it samples the two route request lines, the four presence detectors, the four signal lamps and the switch position. The switch reads high when it is set for route A and low when it is set for route B.

A nine-phase tracker follows each crossing. The phases are idle, then align, start, run and exit for each route. For the phase it currently holds, the monitor checks which lamps must be dark and which way the switch must point. On the first breach it latches a violation flag and a 3-bit rule number, and both stay put until reset.

The monitor only observes and drives nothing on the bridge. The current phase is brought out so that the controller under test can be followed.

Top module: `bridge_excl_monitor`

## Requirements
- R1: After reset `phase_o` is 0 (idle), `viol_o` is 0 and `viol_id_o` is 0.
- R2: In idle, `req_i[0]` moves the phase to 1 (A align) and wins over `req_i[1]`. `req_i[1]` alone moves it to 5 (B align).
- R3: Route A advances 1→2 when `switch_i` is 1, then 2→3 when `det_i[0]` is set, then 3→4 when `det_i[2]` is set. It stays in 4 while `det_i[0]` or `det_i[2]` is set, and returns to 0 once both are clear.
- R4: Route B advances 5→6 when `switch_i` is 0, then 6→7 when `det_i[1]` is set, then 7→8 when `det_i[3]` is set. It stays in 8 while `det_i[1]` or `det_i[3]` is set, and returns to 0 once both are clear.
- R5: In idle, any lit lamp (`lamp_i` nonzero) is rule 1.
- R6: Route A rules apply with `switch_i` required to be 1. Phase 2 breaks rule 2 if `switch_i` is 0 or `lamp_i[1]` or `lamp_i[3]` is set. Phase 3 breaks rule 3 if `switch_i` is 0 or `lamp_i[0]`, `lamp_i[1]` or `lamp_i[3]` is set. Phase 4 breaks rule 4 if `switch_i` is 0 or any lamp is set.
- R7: Route B rules apply with `switch_i` required to be 0. Phase 6 breaks rule 5 if `switch_i` is 1 or `lamp_i[0]` or `lamp_i[2]` is set. Phase 7 breaks rule 6 if `switch_i` is 1 or `lamp_i[0]`, `lamp_i[1]` or `lamp_i[2]` is set. Phase 8 breaks rule 7 if `switch_i` is 1 or any lamp is set.
- R8: In the align phases (1 and 5) no rule applies, and any lamp and switch values leave `viol_o` at 0.
- R9: `viol_o` rises in the cycle after the first offending sample, and `viol_id_o` then holds that rule number. Both stay fixed until reset while phase tracking continues.
- R10: Lamps a rule does not name may be lit without effect. These are `lamp_i[0]` and `lamp_i[2]` in phase 2, `lamp_i[2]` in phase 3, `lamp_i[1]` and `lamp_i[3]` in phase 6, and `lamp_i[3]` in phase 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Route requests: bit 0 route A, bit 1 route B |
| det_i | input | 4 | Presence detectors 1 to 4 at bits 0 to 3 |
| lamp_i | input | 4 | Signal lamps 1 to 4 at bits 0 to 3 |
| switch_i | input | 1 | Switch position: 1 route A, 0 route B |
| phase_o | output | 4 | Current phase, encoded 0 to 8 |
| viol_o | output | 1 | Sticky violation flag |
| viol_id_o | output | 3 | Rule number of the first violation, 0 if none |

## Verification
The exit-phase rules are the hardest to reach. They are only live after a full request, align, start and run walk with the detectors raised in the right order. Each rule check therefore begins with a clean walk that drives the phase to its target state, and only then applies a single offending sample. The flag is sticky, so every rule case starts from a fresh reset. The sticky case deliberately commits a second breach after the first to show that the first rule number is kept.

// File: rtl/bridge_mon_pkg.sv
package bridge_mon_pkg;
  localparam int PHASE_W = 4;
  localparam int ID_W    = 3;
  localparam int N_DET   = 4;
  localparam int N_LAMP  = 4;

  typedef enum logic [PHASE_W-1:0] {
    ST_IDLE    = 4'd0,
    ST_A_ALIGN = 4'd1,
    ST_A_START = 4'd2,
    ST_A_RUN   = 4'd3,
    ST_A_EXIT  = 4'd4,
    ST_B_ALIGN = 4'd5,
    ST_B_START = 4'd6,
    ST_B_RUN   = 4'd7,
    ST_B_EXIT  = 4'd8
  } phase_e;
endpackage

// File: rtl/bridge_phase_fsm.sv
module bridge_phase_fsm
  import bridge_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        req_i,
  input  logic [N_DET-1:0]  det_i,
  input  logic              switch_i,
  output phase_e            phase_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_i[0])      state_d = ST_A_ALIGN;  // route A has priority
        else if (req_i[1]) state_d = ST_B_ALIGN;
      end
      ST_A_ALIGN: if (switch_i)             state_d = ST_A_START;
      ST_A_START: if (det_i[0])             state_d = ST_A_RUN;
      ST_A_RUN:   if (det_i[2])             state_d = ST_A_EXIT;
      ST_A_EXIT:  if (!det_i[0] && !det_i[2]) state_d = ST_IDLE;
      ST_B_ALIGN: if (!switch_i)            state_d = ST_B_START;
      ST_B_START: if (det_i[1])             state_d = ST_B_RUN;
      ST_B_RUN:   if (det_i[3])             state_d = ST_B_EXIT;
      ST_B_EXIT:  if (!det_i[1] && !det_i[3]) state_d = ST_IDLE;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign phase_o = state_q;

  p_req_priority_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i[0]) |=> (state_q == ST_A_ALIGN));
  p_a_exit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_A_EXIT && (det_i[0] || det_i[2])) |=> (state_q == ST_A_EXIT));
  p_b_exit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_B_EXIT && (det_i[1] || det_i[3])) |=> (state_q == ST_B_EXIT));
  p_legal_phase_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q <= ST_B_EXIT));
endmodule

// File: rtl/bridge_rule_check.sv
module bridge_rule_check
  import bridge_mon_pkg::*;
(
  input  phase_e            phase_i,
  input  logic [N_LAMP-1:0] lamp_i,
  input  logic              switch_i,
  output logic [ID_W-1:0]   code_o
);
  logic a_set, b_set;
  assign a_set = switch_i;
  assign b_set = !switch_i;

  // 0 = no breach; otherwise the rule number
  always_comb begin
    code_o = '0;
    case (phase_i)
      ST_IDLE:    if (|lamp_i)                                      code_o = 3'd1;
      ST_A_START: if (!a_set || lamp_i[1] || lamp_i[3])              code_o = 3'd2;
      ST_A_RUN:   if (!a_set || lamp_i[0] || lamp_i[1] || lamp_i[3]) code_o = 3'd3;
      ST_A_EXIT:  if (!a_set || |lamp_i)                            code_o = 3'd4;
      ST_B_START: if (!b_set || lamp_i[0] || lamp_i[2])              code_o = 3'd5;
      ST_B_RUN:   if (!b_set || lamp_i[0] || lamp_i[1] || lamp_i[2]) code_o = 3'd6;
      ST_B_EXIT:  if (!b_set || |lamp_i)                            code_o = 3'd7;
      default:                                                      code_o = '0;
    endcase
  end
endmodule

// File: rtl/bridge_viol_latch.sv
module bridge_viol_latch
  import bridge_mon_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] code_i,
  output logic            viol_o,
  output logic [ID_W-1:0] id_o
);
  logic            viol_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      id_q   <= '0;
    end else if (!viol_q && code_i != '0) begin
      viol_q <= 1'b1;
      id_q   <= code_i;
    end
  end

  assign viol_o = viol_q;
  assign id_o   = id_q;

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> (viol_q && $stable(id_q)));
  p_first_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!viol_q && code_i != '0) |=> (viol_q && id_q == $past(code_i)));
  p_id_present_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |-> (id_q != '0));
endmodule

// File: rtl/bridge_excl_monitor.sv
module bridge_excl_monitor
  import bridge_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        req_i,
  input  logic [N_DET-1:0]  det_i,
  input  logic [N_LAMP-1:0] lamp_i,
  input  logic              switch_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic              viol_o,
  output logic [ID_W-1:0]   viol_id_o
);
  phase_e          phase;
  logic [ID_W-1:0] code;

  bridge_phase_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .det_i    (det_i),
    .switch_i (switch_i),
    .phase_o  (phase)
  );

  bridge_rule_check i_rules (
    .phase_i  (phase),
    .lamp_i   (lamp_i),
    .switch_i (switch_i),
    .code_o   (code)
  );

  bridge_viol_latch i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code),
    .viol_o (viol_o),
    .id_o   (viol_id_o)
  );

  assign phase_o = phase;

  p_idle_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_IDLE && lamp_i != '0 && !viol_o) |=> (viol_o && viol_id_o == 3'd1));
  p_align_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase == ST_A_ALIGN || phase == ST_B_ALIGN) && !viol_o) |=> !viol_o);
  p_a_exit_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_A_EXIT && lamp_i != '0 && !viol_o) |=> (viol_id_o == 3'd4));
  p_b_exit_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_B_EXIT && lamp_i != '0 && !viol_o) |=> (viol_id_o == 3'd7));
endmodule

// File: tb/test_bridge_excl_monitor.sv
module test_bridge_excl_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] req_i = '0;
  logic [3:0] det_i = '0;
  logic [3:0] lamp_i = '0;
  logic       switch_i = 1'b0;
  logic [3:0] phase_o;
  logic       viol_o;
  logic [2:0] viol_id_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bridge_excl_monitor i_bridge_excl_monitor (
    .clk_i, .rst_ni, .req_i, .det_i, .lamp_i, .switch_i,
    .phase_o, .viol_o, .viol_id_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] r, logic [3:0] d, logic [3:0] l, logic s);
    @(negedge clk_i);
    req_i = r; det_i = d; lamp_i = l; switch_i = s;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; det_i = '0; lamp_i = '0; switch_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // clean walk to phase depth on route A (b=0) or B (b=1)
  task automatic walk(bit b, int depth);
    if (!b) begin
      if (depth >= 1) step(2'b01, 4'b0000, 4'b0000, 1'b0);
      if (depth >= 2) step(2'b00, 4'b0000, 4'b0000, 1'b1);
      if (depth >= 3) step(2'b00, 4'b0001, 4'b0000, 1'b1);
      if (depth >= 4) step(2'b00, 4'b0101, 4'b0000, 1'b1);
    end else begin
      if (depth >= 1) step(2'b10, 4'b0000, 4'b0000, 1'b0);
      if (depth >= 2) step(2'b00, 4'b0000, 4'b0000, 1'b0);
      if (depth >= 3) step(2'b00, 4'b0010, 4'b0000, 1'b0);
      if (depth >= 4) step(2'b00, 4'b1010, 4'b0000, 1'b0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 phase", phase_o, 0);
    chk("R1 viol", viol_o, 0);
    chk("R1 id", viol_id_o, 0);
  endtask

  task automatic t_priority();
    do_reset();
    step(2'b11, 4'b0000, 4'b0000, 1'b0);
    chk("R2 both requests", phase_o, 1);
    do_reset();
    step(2'b10, 4'b0000, 4'b0000, 1'b0);
    chk("R2 route B request", phase_o, 5);
  endtask

  task automatic t_route_a();
    do_reset();
    step(2'b01, 4'b0000, 4'b0000, 1'b0);
    chk("R3 align", phase_o, 1);
    step(2'b00, 4'b0000, 4'b1111, 1'b0);
    chk("R8 align lamps phase", phase_o, 1);
    chk("R8 align lamps viol", viol_o, 0);
    step(2'b00, 4'b0000, 4'b0000, 1'b1);
    chk("R3 start", phase_o, 2);
    step(2'b00, 4'b0001, 4'b0101, 1'b1);
    chk("R3 run", phase_o, 3);
    chk("R10 A start lamps", viol_o, 0);
    step(2'b00, 4'b0101, 4'b0100, 1'b1);
    chk("R3 exit", phase_o, 4);
    chk("R10 A run lamp", viol_o, 0);
    step(2'b00, 4'b0100, 4'b0000, 1'b1);
    chk("R3 exit hold", phase_o, 4);
    step(2'b00, 4'b0000, 4'b0000, 1'b1);
    chk("R3 back idle", phase_o, 0);
    chk("R3 clean viol", viol_o, 0);
  endtask

  task automatic t_route_b();
    do_reset();
    step(2'b10, 4'b0000, 4'b0000, 1'b1);
    chk("R4 align", phase_o, 5);
    step(2'b00, 4'b0000, 4'b1111, 1'b1);
    chk("R8 B align lamps phase", phase_o, 5);
    chk("R8 B align lamps viol", viol_o, 0);
    step(2'b00, 4'b0000, 4'b0000, 1'b0);
    chk("R4 start", phase_o, 6);
    step(2'b00, 4'b0010, 4'b1010, 1'b0);
    chk("R4 run", phase_o, 7);
    chk("R10 B start lamps", viol_o, 0);
    step(2'b00, 4'b1010, 4'b1000, 1'b0);
    chk("R4 exit", phase_o, 8);
    chk("R10 B run lamp", viol_o, 0);
    step(2'b00, 4'b0010, 4'b0000, 1'b0);
    chk("R4 exit hold", phase_o, 8);
    step(2'b00, 4'b0000, 4'b0000, 1'b0);
    chk("R4 back idle", phase_o, 0);
    chk("R4 clean viol", viol_o, 0);
  endtask

  // walk to depth, apply one offending sample, expect rule id next cycle
  task automatic t_rule(string req, bit b, int depth, logic [3:0] d,
                        logic [3:0] l, logic s, int exp_id);
    do_reset();
    walk(b, depth);
    chk({req, " pre"}, viol_o, 0);
    step(2'b00, d, l, s);
    chk({req, " flag"}, viol_o, 1);
    chk({req, " id"}, viol_id_o, exp_id);
  endtask

  task automatic t_sticky();
    do_reset();
    step(2'b00, 4'b0000, 4'b0001, 1'b0);
    chk("R9 flag next cycle", viol_o, 1);
    chk("R9 first id", viol_id_o, 1);
    step(2'b01, 4'b0000, 4'b0000, 1'b0);
    chk("R9 tracking continues", phase_o, 1);
    step(2'b00, 4'b0000, 4'b0000, 1'b1);
    step(2'b00, 4'b0000, 4'b0000, 1'b0);
    chk("R9 flag held", viol_o, 1);
    chk("R9 id kept", viol_id_o, 1);
    do_reset();
    #1;
    chk("R9 reset clears", viol_o, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_route_a();
    t_route_b();
    t_rule("R5 idle lamp", 0, 0, 4'b0000, 4'b1000, 1'b0, 1);
    t_rule("R6 A start switch", 0, 2, 4'b0000, 4'b0000, 1'b0, 2);
    t_rule("R6 A start lamp", 0, 2, 4'b0000, 4'b0010, 1'b1, 2);
    t_rule("R6 A run lamp", 0, 3, 4'b0001, 4'b0001, 1'b1, 3);
    t_rule("R6 A exit lamp", 0, 4, 4'b0101, 4'b0100, 1'b1, 4);
    t_rule("R6 A exit switch", 0, 4, 4'b0101, 4'b0000, 1'b0, 4);
    t_rule("R7 B start lamp", 1, 2, 4'b0000, 4'b0001, 1'b0, 5);
    t_rule("R7 B start switch", 1, 2, 4'b0000, 4'b0000, 1'b1, 5);
    t_rule("R7 B run lamp", 1, 3, 4'b0010, 4'b0100, 1'b0, 6);
    t_rule("R7 B exit lamp", 1, 4, 4'b1010, 4'b1000, 1'b0, 7);
    t_rule("R7 B exit switch", 1, 4, 4'b1010, 4'b0000, 1'b1, 7);
    t_sticky();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule